// File: doc/BRIEF.md
# Debug Monitor Entry Controller

At the end of every reset this block decides whether the chip starts in ordinary user mode or in a serial debug monitor mode. It holds that decision for the whole of the next run. The decision is taken once, on the clock that first sees the reset pin high. Two ways lead into the monitor. In the normal path a high-voltage level is detected on the interrupt pin and the select pins show a fixed pattern. In the forced path there is no high voltage and the reset vector is still unprogrammed. In the forced path the select pins are not looked at, and after a power-on reset the block holds the core in one extra reset period before it goes on.

Once in monitor mode, the block points the reset, software-interrupt and break vector fetches one page lower, so that they land in monitor firmware. It controls the watchdog-disable line. It then waits for a fixed number of security bytes from the host. After the last byte it asks the serial transmitter for a break, which is ten zero bits. When the transmitter reports that the break has gone out, the block declares itself ready for commands. Sending the break bits, checking the security bytes and interpreting commands are done by neighbouring blocks.

Top module: `monitor_entry_ctl`

## Requirements
- R1: The mode is captured on the first clock at which the reset pin reads high after being low. Later changes on the select pins, the high-voltage flag or the blank flag do not change `mon_mode` or `mon_forced` until the next reset.
- R2: Normal entry takes place when `hv_irq`=1 and `sel_pins` equals SEL_MATCH (default 3'b101) at release. The result is `mon_mode`=1 and `mon_forced`=0. If `hv_irq`=1 and the pins do not match, the chip starts in user mode.
- R3: Forced entry takes place when `hv_irq`=0 and `vec_blank`=1 at release, whatever `sel_pins` shows. The result is `mon_mode`=1 and `mon_forced`=1. With `hv_irq`=0 and `vec_blank`=0 the chip starts in user mode.
- R4: In monitor mode, `fetch_addr` values 16'hFFFC..16'hFFFF come out on `vec_addr` with the upper byte replaced by 16'hFE. Every other address, and every address in user mode, passes through unchanged.
- R5: After exactly SEC_BYTES (default 8) accepted bytes (`rx_valid`=1), `break_req` pulses high for one cycle. No pulse comes after fewer bytes.
- R6: `cmd_ready` rises only after `tx_break_done` has been seen following the break request, and then stays high.
- R7: In forced monitor mode `wdog_off` is 1 regardless of `hv_irq`. In normal monitor mode it follows `hv_irq`, and once `hv_irq` has dropped it stays 0 until the next reset.
- R8: In user mode `wdog_off`, `break_req`, `cmd_ready` and `extra_rst` stay 0.
- R9: A forced entry with `por`=1 drives `extra_rst` high for EXTRA_CYC (default 16) cycles right after release. Bytes received during that time are not counted. A forced entry with `por`=0 skips it.
- R10: While the reset pin is low, all handshake state is cleared and received bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Reset pin level, active low |
| hv_irq | input | 1 | High voltage detected on interrupt pin |
| sel_pins | input | SEL_W | Mode-select pin levels |
| vec_blank | input | 1 | Reset vector is unprogrammed |
| por | input | 1 | Current reset came from power-on |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_break_done | input | 1 | Transmitter finished the break |
| fetch_addr | input | 16 | Vector fetch address from the core |
| mon_mode | output | 1 | Latched monitor mode |
| mon_forced | output | 1 | Monitor entered through the forced path |
| wdog_off | output | 1 | Watchdog disable |
| vec_addr | output | 16 | Relocated vector address |
| extra_rst | output | 1 | Extra reset period request |
| break_req | output | 1 | One-cycle break transmit request |
| cmd_ready | output | 1 | Ready for monitor commands |

## Verification
The bench changes the select pins and the high-voltage flag after release. A design that samples the pins continuously instead of latching them would change mode partway through a run. Byte counts of seven and eight separate an off-by-one counter. That counter would break early or never. A reset asserted partway through the security bytes exposes a counter that is not cleared, because that design would break after too few bytes. Raising the high voltage again after dropping it in normal mode catches a watchdog disable that is not sticky. Bytes sent during the extra reset period catch a design that counts them, because it would break early.

// File: rtl/monitor_entry_ctl.sv
module monitor_entry_ctl #(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SEL_MATCH = 3'b101,
  parameter int SEC_BYTES = 8,
  parameter int EXTRA_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             hv_irq,
  input  logic [SEL_W-1:0] sel_pins,
  input  logic             vec_blank,
  input  logic             por,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             tx_break_done,
  input  logic [15:0]      fetch_addr,
  output logic             mon_mode,
  output logic             mon_forced,
  output logic             wdog_off,
  output logic [15:0]      vec_addr,
  output logic             extra_rst,
  output logic             break_req,
  output logic             cmd_ready
);
  localparam int CW = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1;
  localparam int XW = (EXTRA_CYC > 1) ? $clog2(EXTRA_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SEC_BYTES - 1);
  localparam logic [XW-1:0] X_LAST = XW'(EXTRA_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_USER, S_EXTRA, S_SEC, S_BRK, S_WAIT, S_READY
  } st_t;

  st_t st;
  logic rst_q, hv_lost;
  logic [CW-1:0] cnt;
  logic [XW-1:0] xcnt;
  logic [7:0] last_byte;

  wire rise = rst_pin_n & ~rst_q;
  wire enter_norm = hv_irq & (sel_pins == SEL_MATCH);
  wire enter_forced = ~hv_irq & vec_blank;

  always_ff @(posedge clk) rst_q <= rst_pin_n;

  always_ff @(posedge clk) begin
    if (!rst_pin_n) begin
      st <= S_IDLE;
      mon_mode <= 1'b0;
      mon_forced <= 1'b0;
      hv_lost <= 1'b0;
      cnt <= '0;
      xcnt <= '0;
      last_byte <= '0;
    end else if (rise) begin
      cnt <= '0;
      xcnt <= X_LAST;
      hv_lost <= 1'b0;
      if (enter_norm) begin
        mon_mode <= 1'b1;
        mon_forced <= 1'b0;
        st <= S_SEC;
      end else if (enter_forced) begin
        mon_mode <= 1'b1;
        mon_forced <= 1'b1;
        st <= por ? S_EXTRA : S_SEC;
      end else begin
        st <= S_USER;
      end
    end else begin
      if (mon_mode && !mon_forced && !hv_irq) hv_lost <= 1'b1;
      case (st)
        S_EXTRA: begin
          if (xcnt == '0) st <= S_SEC;
          else xcnt <= xcnt - 1'b1;
        end
        S_SEC: if (rx_valid) begin
          last_byte <= rx_byte;
          if (cnt == CNT_LAST) st <= S_BRK;
          else cnt <= cnt + 1'b1;
        end
        S_BRK: st <= S_WAIT;
        S_WAIT: if (tx_break_done) st <= S_READY;
        default: ;
      endcase
    end
  end

  assign wdog_off = mon_mode & (mon_forced | (hv_irq & ~hv_lost));
  assign extra_rst = (st == S_EXTRA);
  assign break_req = (st == S_BRK);
  assign cmd_ready = (st == S_READY);
  assign vec_addr = (mon_mode && fetch_addr[15:2] == 14'h3FFF)
                    ? {8'hFE, fetch_addr[7:0]} : fetch_addr;
endmodule

module monitor_entry_chk (
  input logic        clk,
  input logic        rst_pin_n,
  input logic        hv_irq,
  input logic        tx_break_done,
  input logic [15:0] fetch_addr,
  input logic        mon_mode,
  input logic        mon_forced,
  input logic        wdog_off,
  input logic [15:0] vec_addr,
  input logic        extra_rst,
  input logic        break_req,
  input logic        cmd_ready
);
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(rst_pin_n) && $past(mon_mode) |-> $stable(mon_mode) && $stable(mon_forced));
  p_remap_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    mon_mode && fetch_addr == 16'hFFFE |-> vec_addr == 16'hFEFE);
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    break_req |=> !break_req);
  p_ready_after_done_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(cmd_ready) |-> $past(tx_break_done));
  p_forced_wdog_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    mon_mode && mon_forced |-> wdog_off);
  p_user_quiet_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !mon_mode |-> !wdog_off && !break_req && !cmd_ready && !extra_rst);
  p_no_break_in_extra_r9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    extra_rst |-> !break_req && !cmd_ready);
endmodule

bind monitor_entry_ctl monitor_entry_chk u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .hv_irq(hv_irq), .tx_break_done(tx_break_done),
  .fetch_addr(fetch_addr), .mon_mode(mon_mode), .mon_forced(mon_forced),
  .wdog_off(wdog_off), .vec_addr(vec_addr), .extra_rst(extra_rst),
  .break_req(break_req), .cmd_ready(cmd_ready)
);

// File: tb/tb_monitor_entry_ctl.sv
module tb_monitor_entry_ctl;
  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, hv_irq = 1'b0, vec_blank = 1'b0, por = 1'b0;
  logic [2:0] sel_pins = 3'b000;
  logic rx_valid = 1'b0, tx_break_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [15:0] fetch_addr = 16'h0000;
  logic mon_mode, mon_forced, wdog_off, extra_rst, break_req, cmd_ready;
  logic [15:0] vec_addr;
  int errors = 0, checks = 0, brk_n = 0, ext_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  monitor_entry_ctl dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .hv_irq(hv_irq), .sel_pins(sel_pins),
    .vec_blank(vec_blank), .por(por), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_break_done(tx_break_done), .fetch_addr(fetch_addr), .mon_mode(mon_mode),
    .mon_forced(mon_forced), .wdog_off(wdog_off), .vec_addr(vec_addr),
    .extra_rst(extra_rst), .break_req(break_req), .cmd_ready(cmd_ready)
  );

  always @(posedge clk) begin
    if (break_req === 1'b1) brk_n++;
    if (extra_rst === 1'b1) ext_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_reset();
    @(negedge clk) rst_pin_n = 1'b0;
    repeat (2) @(negedge clk);
    brk_n = 0; ext_n = 0;
  endtask

  task automatic release_rst(input logic hv, input logic [2:0] sel,
                             input logic blank, input logic p);
    hv_irq = hv; sel_pins = sel; vec_blank = blank; por = p;
    rst_pin_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_byte = 8'(8'hA0 + i);
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    go_reset();
    chk("R10 reset mon_mode", mon_mode, 0);
    chk("R10 reset break_req/cmd_ready", {break_req, cmd_ready}, 0);
  endtask

  task automatic t_normal();
    go_reset();
    release_rst(1'b1, 3'b101, 1'b0, 1'b1);
    chk("R2 normal mode", {mon_mode, mon_forced}, 2'b10);
    chk("R7 normal wdog_off with hv", wdog_off, 1);
    sel_pins = 3'b000; vec_blank = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mode held after sel change", {mon_mode, mon_forced}, 2'b10);
    fetch_addr = 16'hFFFE; #1 chk("R4 reset vector", vec_addr, 16'hFEFE);
    fetch_addr = 16'hFFFD; #1 chk("R4 swi/break vector", vec_addr, 16'hFEFD);
    fetch_addr = 16'hFFFA; #1 chk("R4 other vector", vec_addr, 16'hFFFA);
    @(negedge clk);
    send(7);
    repeat (3) @(negedge clk);
    chk("R5 no break after 7 bytes", brk_n, 0);
    send(1);
    repeat (3) @(negedge clk);
    chk("R5 one break after 8 bytes", brk_n, 1);
    chk("R6 not ready before done", cmd_ready, 0);
    tx_break_done = 1'b1; @(negedge clk); tx_break_done = 1'b0;
    chk("R6 ready after done", cmd_ready, 1);
    send(3);
    chk("R6 ready holds", cmd_ready, 1);
    chk("R5 no break from later bytes", brk_n, 1);
    hv_irq = 1'b0; @(negedge clk);
    chk("R7 hv dropped", wdog_off, 0);
    hv_irq = 1'b1; repeat (2) @(negedge clk);
    chk("R7 hv back, stays enabled", wdog_off, 0);
  endtask

  task automatic t_forced();
    go_reset();
    release_rst(1'b0, 3'b010, 1'b1, 1'b1);
    chk("R3 forced mode", {mon_mode, mon_forced}, 2'b11);
    chk("R9 extra reset active", extra_rst, 1);
    send(4);
    repeat (20) @(negedge clk);
    chk("R9 extra reset length", ext_n, 16);
    chk("R9 bytes in extra reset ignored", brk_n, 0);
    hv_irq = 1'b1; @(negedge clk);
    chk("R7 forced wdog hv=1", wdog_off, 1);
    hv_irq = 1'b0; @(negedge clk);
    chk("R7 forced wdog hv=0", wdog_off, 1);
    send(7);
    repeat (2) @(negedge clk);
    chk("R9 counting starts after extra reset", brk_n, 0);
    send(1);
    repeat (2) @(negedge clk);
    chk("R5 forced break", brk_n, 1);
    go_reset();
    release_rst(1'b0, 3'b000, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 no extra reset without por", ext_n, 0);
    chk("R3 forced again", {mon_mode, mon_forced}, 2'b11);
  endtask

  task automatic t_user();
    go_reset();
    release_rst(1'b1, 3'b100, 1'b1, 1'b1);
    chk("R2 hv with wrong sel -> user", mon_mode, 0);
    go_reset();
    release_rst(1'b0, 3'b101, 1'b0, 1'b1);
    chk("R3 no hv, programmed -> user", mon_mode, 0);
    fetch_addr = 16'hFFFE; #1 chk("R4 user vector unchanged", vec_addr, 16'hFFFE);
    @(negedge clk);
    hv_irq = 1'b1; vec_blank = 1'b1;
    send(9);
    repeat (2) @(negedge clk);
    chk("R8 user quiet", {wdog_off, cmd_ready, extra_rst}, 0);
    chk("R8 user no break", brk_n, 0);
    chk("R1 user held after pin change", mon_mode, 0);
  endtask

  task automatic t_reset_mid();
    go_reset();
    release_rst(1'b1, 3'b101, 1'b0, 1'b0);
    send(5);
    @(negedge clk) rst_pin_n = 1'b0;
    @(negedge clk);
    send(3);
    release_rst(1'b1, 3'b101, 1'b0, 1'b0);
    send(7);
    repeat (2) @(negedge clk);
    chk("R10 count cleared by reset", brk_n, 0);
    send(1);
    repeat (2) @(negedge clk);
    chk("R10 break after full count", brk_n, 1);
  endtask

  initial begin
    t_reset_state();
    t_normal();
    t_forced();
    t_user();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule